// File: doc/BRIEF.md
# Paged Firmware Download Sequencer

This block moves a firmware image from an incoming byte stream into a program memory window of an embedded microcontroller, and then runs the two-stage handshake that releases the microcontroller to execute it. After a start pulse it raises a download-enable level. It can discard a fixed-size leading header, and it groups the rest of the image into little-endian 32-bit words. Those words are written page by page through a memory window whose active page is chosen with a small page-select field.

When the last word has been written, the enable level drops. The sequencer then waits a bounded number of cycles for the checksum-report status. If that status arrives, it issues a single host-ready write, which also clears the microcontroller-ready bit. It then polls the microcontroller-ready status at a fixed interval, again with a bounded number of tries. The outcome is a one-cycle completion pulse and an error code that stays valid until the next start. A warning flag marks images that have more full pages than the window normally holds.

Top module: `fwdl_seq`

## Requirements
- R1: `dlEn` rises on the cycle after an accepted start. It stays high through every page-select and memory write of the image and is low from the first checksum poll onward. It is low while the block is idle.
- R2: Before the first word of each page, one `pageSelWr` is issued. Its data keeps bits [7:3] of `pageSelCur` and carries the page number (byte offset divided by `PAGE_BYTES`, modulo 8) in bits [2:0]. Pages are numbered upward from 0, and a trailing partial page takes the next number.
- R3: With `hdrPresent` high, the first `HDR_BYTES` stream bytes (or all of them if `imgLen` is smaller) are consumed and never written. The body length becomes `imgLen` minus the bytes skipped.
- R4: The word at body offset k (a multiple of 4) is written to address `WIN_BASE` + (k mod `PAGE_BYTES`). Body byte k+i sits in data bits [8i+7:8i].
- R5: When the body length is not a multiple of 4, the missing bytes of the last word are written as zero and no stream byte is taken for them. No word starts at or past the body length.
- R6: `warnPages` is set when the body holds more than 4 full pages and is cleared by the next start. The download proceeds in either case.
- R7: `chkRptIn` is sampled on each of up to `POLL_LIMIT` consecutive cycles, starting with the first cycle in which `dlEn` is low. If it is never seen, the run ends with error code 1 and no host-ready write.
- R8: Once the checksum is reported, `hostRdyWr` pulses for exactly one cycle while `dlEn` is low. That single write sets host-ready and clears microcontroller-ready.
- R9: `mcuRdyIn` is sampled on the cycle after `hostRdyWr` and then every `POLL_GAP`+1 cycles, `POLL_LIMIT` samples in total. If none of them sees it, the run ends with error code 2. Otherwise it ends with code 0.
- R10: `done` is a single-cycle pulse at the end of each run. `errCode` holds its value until the next accepted start clears it, and a start while a run is in progress is ignored.
- R11: A stream byte is consumed only in a cycle where both `inByteValid` and `inByteReady` are high. Gaps in `inByteValid` stall the sequence without losing or repeating bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a download (taken only while idle) |
| imgLen | input | LEN_W | Image length in bytes, header included |
| hdrPresent | input | 1 | Image begins with a header to skip |
| inByteValid | input | 1 | Stream byte available |
| inByteData | input | 8 | Stream byte |
| inByteReady | output | 1 | Sequencer takes the byte this cycle |
| memWrEn | output | 1 | Program-window word write strobe |
| memWrAddr | output | ADDR_W | Window byte address of the word |
| memWrData | output | 32 | Little-endian word |
| pageSelCur | input | 8 | Current contents of the page-select byte |
| pageSelWr | output | 1 | Page-select byte write strobe |
| pageSelData | output | 8 | New page-select byte |
| dlEn | output | 1 | Download-enable control level |
| chkRptIn | input | 1 | Checksum-report status |
| hostRdyWr | output | 1 | Host-ready write (also clears microcontroller-ready) |
| mcuRdyIn | input | 1 | Microcontroller-ready status |
| done | output | 1 | One-cycle completion pulse |
| errCode | output | 2 | 0 none, 1 checksum timeout, 2 ready timeout |
| warnPages | output | 1 | More than 4 full pages in the body |

## Verification
The first set of images varies the length against the page and word boundaries: a single short page, exactly four and exactly five full pages, lengths ending one to three bytes into a word, and a run long enough that the page number wraps past seven. Together these separate the page numbering, the warning threshold and the zero padding. Headered images of normal, exact-header and shorter-than-header length show whether header bytes leak into the window. A gapped stream and a start pulse during a run show that the stream handshake and the idle-only start hold the byte order. The checksum and ready delays are set one cycle inside and one cycle outside each poll window, which pins down the poll count, the poll spacing and the error codes.

// File: rtl/fwdl_pkg.sv
package fwdl_pkg;

  localparam int WORD_BYTES = 4;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_CHKSUM = 2'd1,
    ERR_READY  = 2'd2
  } fwErr_e;

  // control -> datapath strobes
  typedef struct packed {
    logic load;
    logic skipTake;
    logic laneTake;
    logic lanePad;
    logic wordAdv;
  } dpCmd_t;

  // datapath -> control status
  typedef struct packed {
    logic hdrNone;
    logic hdrLast;
    logic allDone;
    logic pageStart;
    logic laneInBody;
    logic laneLast;
  } dpStat_t;

endpackage

// File: rtl/fwdl_datapath.sv
module fwdl_datapath
  import fwdl_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int ADDR_W     = 16,
  parameter int PAGE_BYTES = 4096,
  parameter int HDR_BYTES  = 32,
  parameter int WIN_BASE   = 'h1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [LEN_W-1:0]  imgLen,
  input  logic              hdrPresent,
  input  logic [7:0]        inByteData,
  input  logic [7:0]        pageSelCur,
  output dpStat_t           stat,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [31:0]       memWrData,
  output logic [7:0]        pageSelData,
  output logic              warnPages
);

  localparam int PAGE_SH = $clog2(PAGE_BYTES);
  localparam int POS_W   = LEN_W + 1;
  localparam int LANE_W  = $clog2(WORD_BYTES);

  logic [LEN_W-1:0]  bodyLen;
  logic [LEN_W-1:0]  hdrLeft;
  logic [POS_W-1:0]  bytePos;
  logic [LANE_W-1:0] lane;
  logic              warnQ;

  // load-time length arithmetic
  logic [LEN_W-1:0] hdrCnt;
  logic [LEN_W-1:0] bodyNext;
  logic [LEN_W-1:0] fullPagesNext;

  always_comb begin
    if (!hdrPresent)                       hdrCnt = '0;
    else if (imgLen < LEN_W'(HDR_BYTES))   hdrCnt = imgLen;
    else                                   hdrCnt = LEN_W'(HDR_BYTES);
    bodyNext      = imgLen - hdrCnt;
    fullPagesNext = bodyNext >> PAGE_SH;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bodyLen <= '0;
      hdrLeft <= '0;
      bytePos <= '0;
      lane    <= '0;
      warnQ   <= 1'b0;
    end else if (cmd.load) begin
      bodyLen <= bodyNext;
      hdrLeft <= hdrCnt;
      bytePos <= '0;
      lane    <= '0;
      warnQ   <= (fullPagesNext > LEN_W'(4));
    end else begin
      if (cmd.skipTake) hdrLeft <= hdrLeft - 1'b1;
      if (cmd.laneTake || cmd.lanePad) lane <= lane + 1'b1;
      if (cmd.wordAdv) begin
        bytePos <= bytePos + POS_W'(WORD_BYTES);
        lane    <= '0;
      end
    end
  end

  // one register per byte lane of the outgoing word
  for (genvar g = 0; g < WORD_BYTES; g++) begin : gLane
    logic [7:0] laneQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        laneQ <= '0;
      else if (cmd.load)
        laneQ <= '0;
      else if ((cmd.laneTake || cmd.lanePad) && lane == LANE_W'(g))
        laneQ <= cmd.laneTake ? inByteData : 8'h00;
    end
    assign memWrData[8*g +: 8] = laneQ;
  end

  logic [POS_W-1:0] laneIdx;
  logic [2:0]       pageNum;

  always_comb begin
    laneIdx         = bytePos + POS_W'(lane);
    pageNum         = 3'(bytePos >> PAGE_SH);
    stat.hdrNone    = (hdrLeft == '0);
    stat.hdrLast    = (hdrLeft == LEN_W'(1));
    stat.allDone    = (bytePos >= {1'b0, bodyLen});
    stat.pageStart  = (bytePos[PAGE_SH-1:0] == '0);
    stat.laneInBody = (laneIdx < {1'b0, bodyLen});
    stat.laneLast   = (lane == LANE_W'(WORD_BYTES - 1));
  end

  assign memWrAddr   = ADDR_W'(WIN_BASE) + ADDR_W'(bytePos[PAGE_SH-1:0]);
  assign pageSelData = {pageSelCur[7:3], pageNum};
  assign warnPages   = warnQ;

  assert_word_aligned_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wordAdv |-> (memWrAddr[1:0] == 2'b00));

  assert_word_inside_body_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wordAdv |-> (bytePos < {1'b0, bodyLen}));

  assert_strobes_exclusive_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.skipTake, cmd.laneTake, cmd.lanePad, cmd.wordAdv}));

endmodule

// File: rtl/fwdl_ctrl.sv
module fwdl_ctrl
  import fwdl_pkg::*;
#(
  parameter int POLL_LIMIT = 1000,
  parameter int POLL_GAP   = 100
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       inByteValid,
  input  logic       chkRptIn,
  input  logic       mcuRdyIn,
  input  dpStat_t    stat,
  output dpCmd_t     cmd,
  output logic       inByteReady,
  output logic       memWrEn,
  output logic       pageSelWr,
  output logic       hostRdyWr,
  output logic       dlEn,
  output logic       done,
  output logic [1:0] errCode
);

  localparam int PC_W = $clog2(POLL_LIMIT + 1);
  localparam int GC_W = $clog2(POLL_GAP + 2);
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(POLL_LIMIT - 1);
  localparam logic [GC_W-1:0] GC_LAST = GC_W'((POLL_GAP > 0) ? POLL_GAP - 1 : 0);

  typedef enum logic [3:0] {
    S_IDLE, S_SKIP, S_NEXT, S_PSEL, S_GATHER, S_WRITE,
    S_FINISH, S_CHK, S_HRDY, S_RPOLL, S_GAP, S_DONE
  } state_e;

  state_e          state, nState;
  logic [PC_W-1:0] pollCnt;
  logic [GC_W-1:0] gapCnt;
  logic            pollMiss, pollClr, errSet;
  fwErr_e          errNext;

  always_comb begin
    nState      = state;
    cmd         = '0;
    inByteReady = 1'b0;
    memWrEn     = 1'b0;
    pageSelWr   = 1'b0;
    hostRdyWr   = 1'b0;
    done        = 1'b0;
    pollMiss    = 1'b0;
    pollClr     = 1'b0;
    errSet      = 1'b0;
    errNext     = ERR_NONE;
    unique case (state)
      S_IDLE: if (start) begin
        cmd.load = 1'b1;
        nState   = S_SKIP;
      end
      S_SKIP: begin
        if (stat.hdrNone) nState = S_NEXT;
        else begin
          inByteReady = 1'b1;
          if (inByteValid) begin
            cmd.skipTake = 1'b1;
            if (stat.hdrLast) nState = S_NEXT;
          end
        end
      end
      S_NEXT: begin
        if (stat.allDone)        nState = S_FINISH;
        else if (stat.pageStart) nState = S_PSEL;
        else                     nState = S_GATHER;
      end
      S_PSEL: begin
        pageSelWr = 1'b1;
        nState    = S_GATHER;
      end
      S_GATHER: begin
        if (stat.laneInBody) begin
          inByteReady = 1'b1;
          if (inByteValid) begin
            cmd.laneTake = 1'b1;
            if (stat.laneLast) nState = S_WRITE;
          end
        end else begin
          cmd.lanePad = 1'b1;
          if (stat.laneLast) nState = S_WRITE;
        end
      end
      S_WRITE: begin
        memWrEn     = 1'b1;
        cmd.wordAdv = 1'b1;
        nState      = S_NEXT;
      end
      S_FINISH: begin
        pollClr = 1'b1;
        nState  = S_CHK;
      end
      S_CHK: begin
        if (chkRptIn) nState = S_HRDY;
        else if (pollCnt == PC_LAST) begin
          errSet  = 1'b1;
          errNext = ERR_CHKSUM;
          nState  = S_DONE;
        end else pollMiss = 1'b1;
      end
      S_HRDY: begin
        hostRdyWr = 1'b1;
        pollClr   = 1'b1;
        nState    = S_RPOLL;
      end
      S_RPOLL: begin
        if (mcuRdyIn) nState = S_DONE;
        else if (pollCnt == PC_LAST) begin
          errSet  = 1'b1;
          errNext = ERR_READY;
          nState  = S_DONE;
        end else begin
          pollMiss = 1'b1;
          nState   = (POLL_GAP == 0) ? S_RPOLL : S_GAP;
        end
      end
      S_GAP: if (gapCnt == GC_LAST) nState = S_RPOLL;
      S_DONE: begin
        done   = 1'b1;
        nState = S_IDLE;
      end
      default: nState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      pollCnt <= '0;
      gapCnt  <= '0;
      dlEn    <= 1'b0;
      errCode <= ERR_NONE;
    end else begin
      state <= nState;
      if (pollClr)       pollCnt <= '0;
      else if (pollMiss) pollCnt <= pollCnt + 1'b1;
      gapCnt <= (state == S_GAP) ? gapCnt + 1'b1 : '0;
      if (cmd.load)               dlEn <= 1'b1;
      else if (state == S_FINISH) dlEn <= 1'b0;
      if (cmd.load)    errCode <= ERR_NONE;
      else if (errSet) errCode <= errNext;
    end
  end

  assert_write_under_enable_R1: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn || pageSelWr) |-> dlEn);

  assert_hostrdy_after_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    hostRdyWr |-> !dlEn);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_err_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.load |=> ($stable(errCode) || done));

endmodule

// File: rtl/fwdl_seq.sv
module fwdl_seq
  import fwdl_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int ADDR_W     = 16,
  parameter int PAGE_BYTES = 4096,
  parameter int HDR_BYTES  = 32,
  parameter int WIN_BASE   = 'h1000,
  parameter int POLL_LIMIT = 1000,
  parameter int POLL_GAP   = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LEN_W-1:0]  imgLen,
  input  logic              hdrPresent,
  input  logic              inByteValid,
  input  logic [7:0]        inByteData,
  output logic              inByteReady,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [31:0]       memWrData,
  input  logic [7:0]        pageSelCur,
  output logic              pageSelWr,
  output logic [7:0]        pageSelData,
  output logic              dlEn,
  input  logic              chkRptIn,
  output logic              hostRdyWr,
  input  logic              mcuRdyIn,
  output logic              done,
  output logic [1:0]        errCode,
  output logic              warnPages
);

  dpCmd_t  cmd;
  dpStat_t stat;

  fwdl_ctrl #(
    .POLL_LIMIT (POLL_LIMIT),
    .POLL_GAP   (POLL_GAP)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .inByteValid (inByteValid),
    .chkRptIn    (chkRptIn),
    .mcuRdyIn    (mcuRdyIn),
    .stat        (stat),
    .cmd         (cmd),
    .inByteReady (inByteReady),
    .memWrEn     (memWrEn),
    .pageSelWr   (pageSelWr),
    .hostRdyWr   (hostRdyWr),
    .dlEn        (dlEn),
    .done        (done),
    .errCode     (errCode)
  );

  fwdl_datapath #(
    .LEN_W      (LEN_W),
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES),
    .HDR_BYTES  (HDR_BYTES),
    .WIN_BASE   (WIN_BASE)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .imgLen      (imgLen),
    .hdrPresent  (hdrPresent),
    .inByteData  (inByteData),
    .pageSelCur  (pageSelCur),
    .stat        (stat),
    .memWrAddr   (memWrAddr),
    .memWrData   (memWrData),
    .pageSelData (pageSelData),
    .warnPages   (warnPages)
  );

endmodule

// File: tb/fwdl_seq_test.sv
module fwdl_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int PB   = 16;
  localparam int HB   = 4;
  localparam int PL   = 6;
  localparam int PG   = 2;
  localparam int LW   = 16;
  localparam int AW   = 16;
  localparam int BASE = 'h1000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [LW-1:0] imgLen = '0;
  logic          hdrPresent = 1'b0;
  logic          inByteValid = 1'b0;
  logic [7:0]    inByteData = '0;
  logic          inByteReady;
  logic          memWrEn;
  logic [AW-1:0] memWrAddr;
  logic [31:0]   memWrData;
  logic [7:0]    pageSelCur = '0;
  logic          pageSelWr;
  logic [7:0]    pageSelData;
  logic          dlEn;
  logic          chkRptIn = 1'b0;
  logic          hostRdyWr;
  logic          mcuRdyIn = 1'b0;
  logic          done;
  logic [1:0]    errCode;
  logic          warnPages;

  fwdl_seq #(
    .LEN_W(LW), .ADDR_W(AW), .PAGE_BYTES(PB), .HDR_BYTES(HB),
    .WIN_BASE(BASE), .POLL_LIMIT(PL), .POLL_GAP(PG)
  ) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model state
  logic [7:0]    streamQ[$];
  logic [7:0]    expPage[$];
  logic [AW-1:0] expAddr[$];
  logic [31:0]   expData[$];
  int  chkDelay = 0, rdyDelay = 1;
  bit  gapMode = 0;
  int  hsCount = 0, doneCount = 0;
  bit  dlSeen = 0, hsSeen = 0;
  int  sinceDl = -1, sinceHs = 0;
  bit  takePending = 0;
  int  cyc = 0;

  // per-clock driver, model and comparison
  always @(negedge clk) begin
    cyc++;
    if (takePending && streamQ.size() > 0) void'(streamQ.pop_front());
    inByteValid = (streamQ.size() > 0) && !(gapMode && (cyc % 3 == 0));
    inByteData  = (streamQ.size() > 0) ? streamQ[0] : 8'h00;
    takePending = inByteValid && inByteReady;

    if (memWrEn) begin
      check("R1", "enable during word write", dlEn, 1);
      if (expAddr.size() == 0) check("R4", "unexpected word write", 1, 0);
      else begin
        check("R4", "word address", memWrAddr, expAddr.pop_front());
        check("R5", "word data", memWrData, expData.pop_front());
      end
    end
    if (pageSelWr) begin
      check("R1", "enable during page select", dlEn, 1);
      if (expPage.size() == 0) check("R2", "unexpected page select", 1, 0);
      else check("R2", "page select byte", pageSelData, expPage.pop_front());
    end
    if (hostRdyWr) begin
      hsCount++;
      check("R8", "enable low at host ready", dlEn, 0);
    end
    if (done) doneCount++;

    if (dlEn) begin dlSeen = 1; sinceDl = -1; end
    else if (dlSeen) sinceDl++;
    chkRptIn = dlSeen && !dlEn && chkDelay >= 0 && sinceDl >= chkDelay;
    if (hostRdyWr) begin hsSeen = 1; sinceHs = 0; end
    else if (hsSeen) sinceHs++;
    mcuRdyIn = hsSeen && rdyDelay >= 0 && sinceHs >= rdyDelay;
  end

  task automatic runCase(string name, int len, bit hdr, logic [7:0] psc,
                         int chkD, int rdyD, bit gaps, int expErr, bit poke);
    int hdrCnt, body, nw, t;
    logic [7:0] img[$];
    bit expWarn;
    hdrCnt = hdr ? ((len < HB) ? len : HB) : 0;
    body   = len - hdrCnt;
    streamQ.delete(); expPage.delete(); expAddr.delete(); expData.delete();
    for (int i = 0; i < hdrCnt; i++) streamQ.push_back(8'hEE);
    for (int i = 0; i < body; i++) begin
      img.push_back(8'((len * 7 + i * 13 + 1) & 255));
      streamQ.push_back(img[i]);
    end
    nw = (body + 3) / 4;
    for (int w = 0; w < nw; w++) begin
      logic [31:0] d;
      int off = w * 4;
      if (off % PB == 0) expPage.push_back({psc[7:3], 3'((off / PB) % 8)});
      d = '0;
      for (int b = 0; b < 4; b++)
        if (off + b < body) d[8*b +: 8] = img[off + b];
      expAddr.push_back(AW'(BASE + off % PB));
      expData.push_back(d);
    end
    expWarn = (body / PB) > 4;
    pageSelCur = psc; chkDelay = chkD; rdyDelay = rdyD; gapMode = gaps;
    dlSeen = 0; hsSeen = 0; hsCount = 0; doneCount = 0;
    imgLen = LW'(len); hdrPresent = hdr;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R10", {name, ": error cleared by start"}, errCode, 0);
    check("R1", {name, ": enable raised after start"}, dlEn, 1);
    if (poke) begin
      repeat (6) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    t = 0;
    while (doneCount == 0 && t < 5000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
    check("R10", {name, ": single done pulse"}, doneCount, 1);
    check(expErr == 1 ? "R7" : "R9", {name, ": error code"}, errCode, expErr);
    check("R6", {name, ": page warning"}, warnPages, expWarn);
    check("R4", {name, ": all words written"}, expAddr.size(), 0);
    check("R2", {name, ": all page selects issued"}, expPage.size(), 0);
    check("R11", {name, ": stream fully consumed"}, streamQ.size(), 0);
    check("R8", {name, ": host ready writes"}, hsCount, (expErr == 1) ? 0 : 1);
    check("R1", {name, ": enable low when idle"}, dlEn, 0);
    check("R10", {name, ": error code held"}, errCode, expErr);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset enable", dlEn, 0);
    check("R10", "reset done", done, 0);
    check("R10", "reset error", errCode, 0);
    check("R6", "reset warning", warnPages, 0);
    check("R11", "reset ready", inByteReady, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    runCase("short R4", 8, 0, 8'h00, 0, 1, 0, 0, 0);
    runCase("gapped five pages R5 R6 R11", 90, 0, 8'hA8, 2, 4, 1, 0, 0);
    runCase("header R3", 41, 1, 8'h5F, 1, 7, 0, 0, 0);
    runCase("four pages R6", 64, 0, 8'h30, 0, 1, 0, 0, 0);
    runCase("five pages R6", 80, 0, 8'h30, 0, 1, 0, 0, 0);
    runCase("page wrap busy start R2 R10", 130, 0, 8'hF9, 3, 2, 1, 0, 1);
    runCase("chk last poll R7", 13, 0, 8'h00, PL - 1, 1, 0, 0, 0);
    runCase("chk timeout R7", 13, 0, 8'h00, PL, 1, 0, 1, 0);
    runCase("rdy last poll R9", 7, 0, 8'h00, 0, 1 + (PL - 1) * (PG + 1), 0, 0, 0);
    runCase("rdy timeout R9", 7, 0, 8'h00, 0, 2 + (PL - 1) * (PG + 1), 0, 2, 0);
    runCase("short header R3", 3, 1, 8'h00, 0, 1, 0, 0, 0);
    runCase("exact header R3", 4, 1, 8'h00, -1, 1, 0, 1, 0);
    runCase("pad three R5", 17, 0, 8'h00, 0, 3, 0, 0, 0);

    summary();
    $finish;
  end

endmodule